// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block joins a 32-bit register file to a 32-bit data bus for byte, word and longword accesses. For every request it checks the address against the size of the access. A word needs an even address and a longword needs an address that is a multiple of four. A request that breaks this rule is reported as an address error. No bus write and no register write are issued for it.

For a legal store, the block places the low-order bytes of the source register on the byte lanes that the address selects. It also drives a 4-bit byte-enable vector for those lanes. For a legal load, it takes the addressed bytes from the raw bus word, sign-extends them to 32 bits and asserts the register write. The request path is combinational.

The byte order comes from a mode input. That input is sampled only while the power-on reset is held and is locked for the rest of the run.

Top module: `lsu_align`

## Requirements
- R1: `req_size` encodes 00 = byte, 01 = word, 10 = longword, and 11 is handled exactly as a longword. A byte access never raises `addr_err` at any address.
- R2: A valid word access with `req_addr[0]` = 1 raises `addr_err`. With `req_addr[0]` = 0 it does not.
- R3: A valid longword access with `req_addr[1:0]` other than 00 raises `addr_err`. With 00 it does not.
- R4: While `addr_err` is high, `mem_be` is 0000 and `mem_we`, `rf_we` and `mem_wdata` are all zero.
- R5: The byte order is taken from `endian_pin` at each rising clock edge while `rst_por_n` is low (0 = big-endian, 1 = little-endian). Changes on `endian_pin` after reset have no effect.
- R6: Byte lanes: lane k is `mem_wdata`/`ld_rdata` bits 8k+7:8k and `mem_be[k]`. In little-endian mode a byte at offset o uses lane o. In big-endian mode it uses lane 3-o.
- R7: A word at offset 0 uses lanes 1:0 in little-endian mode and lanes 3:2 in big-endian mode. A word at offset 2 uses the opposite pair. The lower-addressed byte is the least significant byte of the word in little-endian mode and the most significant byte in big-endian mode.
- R8: A legal longword uses `mem_be` = 1111 and passes the 32-bit data unchanged in both directions.
- R9: A legal store drives `mem_we` high and puts `st_data[7:0]` (byte) or `st_data[15:0]` (word) on the selected lanes. All other lanes are zero.
- R10: A legal load drives `rf_we` high. `ld_result` is the addressed byte or word from `ld_rdata`, sign-extended from its top bit to 32 bits.
- R11: `mem_addr` equals `req_addr` with bits 1:0 cleared.
- R12: With `req_valid` low, `mem_be`, `mem_we`, `rf_we`, `addr_err` and `mem_wdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, synchronous |
| endian_pin | input | 1 | Byte-order mode, sampled only during reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | AW | Byte address |
| st_data | input | 32 | Store source register value |
| ld_rdata | input | 32 | Raw bus word for loads |
| mem_addr | output | AW | Word-aligned bus address |
| mem_be | output | 4 | Byte-lane enables |
| mem_we | output | 1 | Bus write strobe |
| mem_wdata | output | 32 | Lane-steered store data |
| addr_err | output | 1 | Misaligned access flag |
| ld_result | output | 32 | Sign-extended load value |
| rf_we | output | 1 | Register write enable for loads |

## Verification
Every size is driven at all four address offsets, as both a load and a store, in each byte order. This separates lane reversal from offset selection, and legal offsets from misaligned ones. Load words carry bytes with mixed sign bits, such as 0x81, 0x7F and 0xF2, so sign extension from the wrong lane or the wrong bit shows up. The mode input is toggled after each reset to show that the latched order holds. Randomized requests then mix sizes, directions and addresses against a byte-by-byte model of memory.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_por_n,
  input  logic          endian_pin,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   st_data,
  input  logic [31:0]   ld_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic          mem_we,
  output logic [31:0]   mem_wdata,
  output logic          addr_err,
  output logic [31:0]   ld_result,
  output logic          rf_we
);

  logic le_q;

  always_ff @(posedge clk) begin
    if (!rst_por_n) le_q <= endian_pin;
  end

  logic [1:0]  off;
  logic        is_byte, is_word, is_long, misal, go;
  logic [1:0]  lane;
  logic [3:0]  lane_mask;
  logic [31:0] data_mask;
  logic [4:0]  shamt;
  logic [15:0] ext;

  assign off     = req_addr[1:0];
  assign is_byte = (req_size == 2'b00);
  assign is_word = (req_size == 2'b01);
  assign is_long = req_size[1];
  assign misal   = (is_word & off[0]) | (is_long & (off != 2'b00));
  assign go      = req_valid & ~misal;

  always_comb begin
    if (is_byte) begin
      lane      = le_q ? off : ~off;
      lane_mask = 4'b0001;
      data_mask = 32'h0000_00FF;
    end else if (is_word) begin
      lane      = {le_q ? off[1] : ~off[1], 1'b0};
      lane_mask = 4'b0011;
      data_mask = 32'h0000_FFFF;
    end else begin
      lane      = 2'b00;
      lane_mask = 4'b1111;
      data_mask = 32'hFFFF_FFFF;
    end
  end

  assign shamt     = {lane, 3'b000};
  assign mem_addr  = {req_addr[AW-1:2], 2'b00};
  assign addr_err  = req_valid & misal;
  assign mem_be    = go ? (lane_mask << lane) : 4'b0000;
  assign mem_we    = go & req_write;
  assign mem_wdata = (go & req_write) ? ((st_data & data_mask) << shamt) : 32'h0;
  assign rf_we     = go & ~req_write;

  assign ext = 16'(ld_rdata >> shamt);

  always_comb begin
    if (is_byte)      ld_result = {{24{ext[7]}}, ext[7:0]};
    else if (is_word) ld_result = {{16{ext[15]}}, ext};
    else              ld_result = ld_rdata;
  end

endmodule

module lsu_align_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_por_n,
  input logic          le_q,
  input logic          req_valid,
  input logic          req_write,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic [3:0]    mem_be,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic          addr_err,
  input logic          rf_we
);

  // R1
  byte_no_err_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (req_valid && req_size == 2'b00) |-> !addr_err);

  // R2
  word_odd_err_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (req_valid && req_size == 2'b01 && req_addr[0]) |-> addr_err);

  // R3
  long_misal_err_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (req_valid && req_size[1] && req_addr[1:0] != 2'b00) |-> addr_err);

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    addr_err |-> (mem_be == 4'b0000 && !mem_we && !rf_we && mem_wdata == 32'h0));

  // R5
  endian_locked_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    $past(rst_por_n) |-> $stable(le_q));

  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (req_valid && req_size == 2'b00) |-> $countones(mem_be) == 1);

  // R7
  word_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (req_valid && req_size == 2'b01 && !addr_err) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  // R8
  long_all_lane_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (req_valid && req_size[1] && !addr_err) |-> mem_be == 4'b1111);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    !req_valid |-> (mem_be == 4'b0000 && !mem_we && !rf_we && !addr_err));

  // R9
  we_rf_excl_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    !(mem_we && rf_we));

endmodule

bind lsu_align lsu_align_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_por_n(rst_por_n), .le_q(le_q), .req_valid(req_valid),
  .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
  .mem_be(mem_be), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .addr_err(addr_err), .rf_we(rf_we)
);

// File: tb/tb_lsu_align.sv
module tb_lsu_align;

  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0;
  logic        endian_pin = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = 32'h0;
  logic [31:0] st_data = 32'h0;
  logic [31:0] ld_rdata = 32'h0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic        addr_err;
  logic [31:0] ld_result;
  logic        rf_we;

  int  n_run = 0;
  int  n_fail = 0;
  bit  model_le = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  lsu_align dut (
    .clk(clk), .rst_por_n(rst_por_n), .endian_pin(endian_pin),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .st_data(st_data), .ld_rdata(ld_rdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .addr_err(addr_err), .ld_result(ld_result),
    .rf_we(rf_we)
  );

  task automatic finish_bench();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(bit le);
    rst_por_n  = 1'b0;
    endian_pin = le;
    req_valid  = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_por_n = 1'b1;
    model_le = le;
    #3 endian_pin = ~le;
  endtask

  task automatic access(string tag, bit v, bit w, logic [1:0] sz,
                        logic [31:0] a, logic [31:0] d, logic [31:0] r);
    int n;
    int off;
    bit mis;
    bit ok;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    logic [31:0] e_ld;
    @(posedge clk);
    #2;
    req_valid = v; req_write = w; req_size = sz;
    req_addr = a; st_data = d; ld_rdata = r;
    n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    off = int'(a[1:0]);
    mis = (n == 2 && a[0]) || (n == 4 && off != 0);
    ok  = v && !mis;
    e_be = 4'b0; e_wd = 32'h0; e_ld = 32'h0;
    for (int i = 0; i < n; i++) begin
      int mb;
      int ln;
      int rb;
      mb = (n == 4) ? i : off + i;
      ln = model_le ? mb : 3 - mb;
      rb = model_le ? i : n - 1 - i;
      e_be[ln] = 1'b1;
      e_wd[ln*8 +: 8] = d[rb*8 +: 8];
      e_ld[rb*8 +: 8] = r[ln*8 +: 8];
    end
    for (int k = n * 8; k < 32; k++) e_ld[k] = e_ld[n*8-1];
    if (!ok) e_be = 4'b0;
    if (!(ok && w)) e_wd = 32'h0;
    @(negedge clk);
    chk(tag, "addr_err", 32'(addr_err), 32'(v && mis));
    chk(tag, "mem_be", 32'(mem_be), 32'(e_be));
    chk(tag, "mem_we", 32'(mem_we), 32'(ok && w));
    chk(tag, "rf_we", 32'(rf_we), 32'(ok && !w));
    chk(tag, "mem_wdata", mem_wdata, e_wd);
    chk("R11", "mem_addr", mem_addr, {a[31:2], 2'b00});
    if (ok && !w) chk(tag, "ld_result", ld_result, e_ld);
  endtask

  task automatic sweep();
    for (int o = 0; o < 4; o++) begin
      access("R6", 1, 1, 2'b00, 32'h1000_0000 + o, 32'hCAFE_BEA5, 32'h0);
      access("R6", 1, 0, 2'b00, 32'h1000_0000 + o, 32'h0, 32'h81F2_7F93);
      access((o % 2) ? "R2" : "R7", 1, 1, 2'b01, 32'h2000_0000 + o, 32'h1234_8A7C, 32'h0);
      access((o % 2) ? "R2" : "R7", 1, 0, 2'b01, 32'h2000_0000 + o, 32'h0, 32'h7F80_8001);
      access((o == 0) ? "R8" : "R3", 1, 1, 2'b10, 32'h3000_0000 + o, 32'hDEAD_0123, 32'h0);
      access((o == 0) ? "R8" : "R3", 1, 0, 2'b10, 32'h3000_0000 + o, 32'h0, 32'h9ABC_DEF0);
      access("R1", 1, 0, 2'b11, 32'h4000_0000 + o, 32'h0, 32'h8000_0001);
      access("R4", 1, 1, 2'b11, 32'h4000_0004 + o, 32'hFFFF_FFFF, 32'h0);
    end
    access("R9", 1, 1, 2'b00, 32'h5000_0002, 32'hFFFF_FF00, 32'h0);
    access("R10", 1, 0, 2'b01, 32'h5000_0002, 32'h0, 32'h0000_7FFF);
    access("R10", 1, 0, 2'b00, 32'h5000_0001, 32'h0, 32'h8080_8080);
    access("R12", 0, 1, 2'b10, 32'h6000_0000, 32'h1111_1111, 32'h2222_2222);
    access("R12", 0, 0, 2'b01, 32'h6000_0001, 32'h0, 32'h3333_3333);
    for (int j = 0; j < 40; j++) begin
      access("R10", 1, 1'($urandom), 2'($urandom), $urandom, $urandom, $urandom);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_bench();
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    chk("R12", "reset mem_be", 32'(mem_be), 32'h0);
    chk("R12", "reset mem_we", 32'(mem_we), 32'h0);
    chk("R12", "reset rf_we", 32'(rf_we), 32'h0);
    chk("R12", "reset addr_err", 32'(addr_err), 32'h0);
    access("R5", 1, 1, 2'b00, 32'h0000_0000, 32'h0000_00AA, 32'h0);
    sweep();
    endian_pin = 1'b0;
    do_reset(1'b1);
    access("R5", 1, 1, 2'b00, 32'h0000_0000, 32'h0000_00AA, 32'h0);
    sweep();
    endian_pin = 1'b1;
    access("R5", 1, 0, 2'b01, 32'h0000_0002, 32'h0, 32'hF00D_1234);
    finish_bench();
  end

endmodule